// File: doc/BRIEF.md
# Dual-Group Audio Output Serializer

This block turns a set of parallel audio sample words into serial bit streams on eight output data pins. The pins are split into two groups of four. Each group has its own bit clock and left/right (frame) clock, and each has its own serial format. Two downstream converters that expect different framing can therefore be fed at the same time. Each group's clock pair is either generated here as master, with the bit clock divided down from the system clock, or received from outside as slave. In slave mode the incoming clocks are synchronised and their edges detected on the system clock.

Every group is controlled by a small state machine with three states. `ST_HUNT` is a slave that has not yet seen a frame boundary. `ST_SLAVE` is a slave that is locked to the external frame. `ST_MASTER` is a group that drives its own clocks. There are four transitions:
- reset enters `ST_HUNT`, so both clock pairs come up as inputs;
- a configuration write with the master bit set moves to `ST_MASTER` (*configure-master*);
- a configuration write with the master bit clear moves to `ST_HUNT` (*configure-slave*);
- the first frame boundary seen on the incoming clocks moves `ST_HUNT` to `ST_SLAVE` (*frame-found*).

Sample words are taken into a per-group shadow copy on the first bit of each frame. The inputs only need to be steady at each frame start.

Top module: `audio_out_serializer`

## Requirements
- R1: After reset, both groups are slaves: `clk_oe`, `bclk_out`, `lrclk_out` and `sdata_out` are all zero. After a configuration write, `clk_oe[g]` equals the written master bit, and a write with master bit 1 is the only way `clk_oe[g]` rises.
- R2: In master mode the bit clock period is `div` system clocks (even `div` ≥ 2, field `cfg_div[g]`), with a high phase of `div/2` clocks.
- R3: In master mode the left/right clock changes only when the bit clock falls. In 2-channel formats it is 0 for bit positions 0..SLOT_W-1 (left slot) and 1 for the next SLOT_W (right slot). In TDM formats it is 1 only during bit position 0 of the frame.
- R4: Format code 0 (I2S-style): within each slot the word is sent MSB first, starting one bit clock after the slot begins. The remaining slot bits are zero.
- R5: Format code 1 (left-justified): the word MSB occupies slot bit 0, and slot bits WORD_W and above are zero.
- R6: Format code 2 (right-justified): the word LSB occupies the last bit of the slot, and the leading SLOT_W-WORD_W bits are zero.
- R7: In the 2-channel formats, pin p of group g carries channel 8g+2p in the left slot and channel 8g+2p+1 in the right slot, so the eight pins carry 16 channels.
- R8: Format code 3 (dual-wire 8-slot TDM): the first pin of group g carries channels 8g..8g+7 in slots 0..7, each left-justified in a SLOT_W-bit slot. The other three pins of the group drive zero.
- R9: Format code 4 (single-wire 16-slot TDM): on group 0, pin 0 carries channels 0..15 in slots 0..15, and pins 1..3 drive zero. A group 1 set to code 4 drives zero on all its pins while still framing 16 slots.
- R10: In slave mode the group follows the external bit clock and left/right clock, using the same framing and channel placement as master mode, and keeps its own clock outputs and `clk_oe` at zero.
- R11: A slave group drives zero on its pins until it sees a frame boundary: a high-to-low left/right transition in 2-channel formats, or a high left/right clock at a bit clock fall in TDM.
- R12: The two groups run independently: each keeps its own format, divider and direction while the other is reconfigured or runs in another format.
- R13: Serial data on a master group changes only on the falling edge of its bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 2 | Per-group configuration write strobe |
| cfg_master | input | 2 | Per-group master (1) / slave (0) select |
| cfg_fmt | input | 6 | Per-group 3-bit format code, group g at bits 3g+2..3g |
| cfg_div | input | 2*DIV_W | Per-group bit-clock divide ratio |
| ch_data | input | 16*WORD_W | Channel sample words, channel c at bits c*WORD_W upward |
| bclk_in | input | 2 | External bit clock per group (slave) |
| lrclk_in | input | 2 | External left/right clock per group (slave) |
| bclk_out | output | 2 | Generated bit clock per group (master) |
| lrclk_out | output | 2 | Generated left/right clock per group (master) |
| clk_oe | output | 2 | Clock pad drive enable per group (1 = master) |
| sdata_out | output | 8 | Serial data pins, group g on pins 4g..4g+3 |

## Verification
The bench builds the block with WORD_W=24, SLOT_W=32 and four pins per group, so 16 channels fill 512-bit single-wire TDM frames. The 8-bit gap between word and slot makes the I2S one-bit delay, the left-justified zero tail and the right-justified zero head land on different bit positions, which lets a wrong offset be detected. Divide ratios from 2 to 8 cover the fastest bit clock, where every other system cycle is a falling edge, as well as slower ones. Slave runs use a bit clock of eight system clocks, which leaves room for the synchroniser latency before the receiving edge.

// File: rtl/aos_pkg.sv
package aos_pkg;

    typedef enum logic [2:0] {
        FMT_I2S   = 3'd0,
        FMT_LJ    = 3'd1,
        FMT_RJ    = 3'd2,
        FMT_TDM8  = 3'd3,
        FMT_TDM16 = 3'd4
    } fmt_e;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_SLAVE  = 2'd1,
        ST_MASTER = 2'd2
    } clk_st_e;

endpackage

// File: rtl/aos_clkgen.sv
module aos_clkgen
    import aos_pkg::*;
#(
    parameter int SLOT_W  = 32,
    parameter int SLOTS_A = 8,
    parameter int SLOTS_B = 16,
    parameter int DIV_W   = 8,
    parameter int POS_W   = $clog2(SLOTS_B * SLOT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_master,
    input  fmt_e             cfg_fmt,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             bclk_in,
    input  logic             lrclk_in,
    output logic             tick,
    output logic [POS_W-1:0] pos_next,
    output fmt_e             fmt,
    output logic             hunting,
    output logic             bclk_o,
    output logic             lrclk_o,
    output logic             oe
);

    localparam logic [POS_W-1:0] LAST_2CH = POS_W'(2 * SLOT_W - 1);
    localparam logic [POS_W-1:0] LAST_A   = POS_W'(SLOTS_A * SLOT_W - 1);
    localparam logic [POS_W-1:0] LAST_B   = POS_W'(SLOTS_B * SLOT_W - 1);
    localparam logic [POS_W-1:0] RIGHT_AT = POS_W'(SLOT_W);

    clk_st_e          st_q, st_d;
    fmt_e             fmt_q;
    logic [DIV_W-1:0] div_q, dcnt_q, half_w, half_m1;
    logic             bclk_q, lrclk_q;
    logic [POS_W-1:0] pos_q, pos_inc, last_pos, s_edge_pos;
    logic             b_s1, b_s2, b_s3, l_s1, l_s2, lr_prev_q;
    logic             is_tdm, m_fall, s_fall, s_edge, lock_hit;

    // derived timing terms
    always_comb begin
        unique case (fmt_q)
            FMT_TDM8:  last_pos = LAST_A;
            FMT_TDM16: last_pos = LAST_B;
            default:   last_pos = LAST_2CH;
        endcase
        is_tdm     = (fmt_q == FMT_TDM8) || (fmt_q == FMT_TDM16);
        pos_inc    = (pos_q == last_pos) ? '0 : pos_q + 1'b1;
        half_w     = {1'b0, div_q[DIV_W-1:1]};
        half_m1    = (half_w == '0) ? '0 : half_w - 1'b1;
        m_fall     = bclk_q && (dcnt_q == half_m1);
        s_fall     = b_s3 && !b_s2;
        s_edge     = is_tdm ? l_s2 : (l_s2 != lr_prev_q);
        s_edge_pos = (!is_tdm && l_s2) ? RIGHT_AT : '0;
        lock_hit   = is_tdm ? l_s2 : (lr_prev_q && !l_s2);
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d = cfg_master ? ST_MASTER : ST_HUNT;
        end else begin
            unique case (st_q)
                ST_HUNT:   if (s_fall && lock_hit) st_d = ST_SLAVE;
                ST_SLAVE:  st_d = ST_SLAVE;
                ST_MASTER: st_d = ST_MASTER;
                default:   st_d = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HUNT;
        else        st_q <= st_d;
    end

    // outputs of the state machine
    always_comb begin
        tick     = 1'b0;
        pos_next = pos_inc;
        unique case (st_q)
            ST_MASTER: tick = m_fall;
            ST_SLAVE: begin
                tick     = s_fall;
                pos_next = s_edge ? s_edge_pos : pos_inc;
            end
            ST_HUNT: begin
                tick     = s_fall && lock_hit;
                pos_next = s_edge_pos;
            end
            default: tick = 1'b0;
        endcase
        if (cfg_we) tick = 1'b0;
        fmt     = fmt_q;
        hunting = (st_q == ST_HUNT);
        oe      = (st_q == ST_MASTER);
        bclk_o  = bclk_q;
        lrclk_o = lrclk_q;
    end

    // input synchronisers, run in every state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_s1 <= 1'b0; b_s2 <= 1'b0; b_s3 <= 1'b0;
            l_s1 <= 1'b0; l_s2 <= 1'b0;
        end else begin
            b_s1 <= bclk_in;  b_s2 <= b_s1; b_s3 <= b_s2;
            l_s1 <= lrclk_in; l_s2 <= l_s1;
        end
    end

    // configuration, divider, frame position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q     <= FMT_I2S;
            div_q     <= DIV_W'(2);
            dcnt_q    <= '0;
            bclk_q    <= 1'b0;
            lrclk_q   <= 1'b0;
            pos_q     <= '1;
            lr_prev_q <= 1'b0;
        end else if (cfg_we) begin
            fmt_q     <= cfg_fmt;
            div_q     <= cfg_div;
            dcnt_q    <= '0;
            bclk_q    <= 1'b0;
            lrclk_q   <= 1'b0;
            pos_q     <= '1;
            lr_prev_q <= 1'b0;
        end else begin
            if (st_q == ST_MASTER) begin
                if (dcnt_q == half_m1) begin
                    dcnt_q <= '0;
                    bclk_q <= ~bclk_q;
                    if (bclk_q)
                        lrclk_q <= is_tdm ? (pos_inc == '0) : (pos_inc >= RIGHT_AT);
                end else begin
                    dcnt_q <= dcnt_q + 1'b1;
                end
            end else if (s_fall) begin
                lr_prev_q <= l_s2;
            end
            if (tick) pos_q <= pos_next;
        end
    end

    // R1
    master_only_by_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(cfg_we && cfg_master));

    // R1
    slave_after_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_we) && !$past(cfg_master)) |-> !oe);

    // R3
    lr_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && $past(oe) && !$past(cfg_we) && lrclk_q != $past(lrclk_q))
        |-> ($past(bclk_q) && !bclk_q));

endmodule

// File: rtl/aos_lane.sv
module aos_lane
    import aos_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int SLOT_W = 32,
    parameter int LANES  = 4,
    parameter int NCH    = 16,
    parameter int GRP    = 0,
    parameter int LANE   = 0,
    parameter int POS_W  = 9
) (
    input  fmt_e                    fmt,
    input  logic [POS_W-1:0]        pos,
    input  logic [NCH*WORD_W-1:0]   words,
    output logic                    bit_o
);

    localparam int SL      = $clog2(SLOT_W);
    localparam int GRP_CH0 = GRP * 2 * LANES;
    localparam int RJ_OFS  = SLOT_W - WORD_W;

    logic [POS_W-SL-1:0] slot;
    logic [SL-1:0]       sb;
    int                  ch, k, idx;
    logic                use_lane;

    always_comb begin
        slot     = pos[POS_W-1:SL];
        sb       = pos[SL-1:0];
        ch       = 0;
        k        = -1;
        use_lane = 1'b0;
        unique case (fmt)
            FMT_I2S, FMT_LJ, FMT_RJ: begin
                use_lane = 1'b1;
                ch       = GRP_CH0 + 2 * LANE + int'(slot[0]);
                if (fmt == FMT_I2S)     k = int'(sb) - 1;
                else if (fmt == FMT_LJ) k = int'(sb);
                else                    k = int'(sb) - RJ_OFS;
            end
            FMT_TDM8: begin
                use_lane = (LANE == 0);
                ch       = GRP_CH0 + int'(slot);
                k        = int'(sb);
            end
            FMT_TDM16: begin
                use_lane = (GRP == 0) && (LANE == 0);
                ch       = int'(slot);
                k        = int'(sb);
            end
            default: use_lane = 1'b0;
        endcase
        if (use_lane && k >= 0 && k < WORD_W && ch < NCH) begin
            idx   = ch * WORD_W + WORD_W - 1 - k;
            bit_o = words[idx];
        end else begin
            idx   = 0;
            bit_o = 1'b0;
        end
    end

endmodule

// File: rtl/aos_group.sv
module aos_group
    import aos_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int SLOT_W = 32,
    parameter int LANES  = 4,
    parameter int NCH    = 16,
    parameter int DIV_W  = 8,
    parameter int GRP    = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic                  cfg_master,
    input  fmt_e                  cfg_fmt,
    input  logic [DIV_W-1:0]      cfg_div,
    input  logic [NCH*WORD_W-1:0] words,
    input  logic                  bclk_in,
    input  logic                  lrclk_in,
    output logic                  bclk_o,
    output logic                  lrclk_o,
    output logic                  oe,
    output logic [LANES-1:0]      sdata
);

    localparam int POS_W = $clog2(NCH * SLOT_W);

    logic                  tick, hunting;
    logic [POS_W-1:0]      pos_next;
    fmt_e                  fmt;
    logic [NCH*WORD_W-1:0] shadow_q, src;
    logic [LANES-1:0]      bit_d, pins_q;

    aos_clkgen #(
        .SLOT_W (SLOT_W),
        .SLOTS_A(2 * LANES),
        .SLOTS_B(NCH),
        .DIV_W  (DIV_W),
        .POS_W  (POS_W)
    ) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_master(cfg_master),
        .cfg_fmt   (cfg_fmt),
        .cfg_div   (cfg_div),
        .bclk_in   (bclk_in),
        .lrclk_in  (lrclk_in),
        .tick      (tick),
        .pos_next  (pos_next),
        .fmt       (fmt),
        .hunting   (hunting),
        .bclk_o    (bclk_o),
        .lrclk_o   (lrclk_o),
        .oe        (oe)
    );

    assign src = (pos_next == '0) ? words : shadow_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        aos_lane #(
            .WORD_W(WORD_W), .SLOT_W(SLOT_W), .LANES(LANES), .NCH(NCH),
            .GRP(GRP), .LANE(l), .POS_W(POS_W)
        ) u_lane (
            .fmt  (fmt),
            .pos  (pos_next),
            .words(src),
            .bit_o(bit_d[l])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q   <= '0;
            shadow_q <= '0;
        end else if (cfg_we) begin
            pins_q   <= '0;
        end else if (tick) begin
            pins_q <= bit_d;
            if (pos_next == '0) shadow_q <= words;
        end
    end

    assign sdata = pins_q;

    // R11
    hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hunting |-> (sdata == '0));

    // R13
    data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && $past(oe) && !$past(cfg_we) && sdata != $past(sdata))
        |-> ($past(bclk_o) && !bclk_o));

    // R8
    tdm8_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_TDM8) |-> (sdata[LANES-1:1] == '0));

    if (GRP != 0) begin : g_far_chk
        // R9
        tdm16_far_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fmt == FMT_TDM16) |-> (sdata == '0));
    end

endmodule

// File: rtl/audio_out_serializer.sv
module audio_out_serializer
    import aos_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int SLOT_W = 32,
    parameter int LANES  = 4,
    parameter int DIV_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   cfg_we,
    input  logic [1:0]                   cfg_master,
    input  logic [5:0]                   cfg_fmt,
    input  logic [2*DIV_W-1:0]           cfg_div,
    input  logic [4*LANES*WORD_W-1:0]    ch_data,
    input  logic [1:0]                   bclk_in,
    input  logic [1:0]                   lrclk_in,
    output logic [1:0]                   bclk_out,
    output logic [1:0]                   lrclk_out,
    output logic [1:0]                   clk_oe,
    output logic [2*LANES-1:0]           sdata_out
);

    localparam int GROUPS = 2;
    localparam int NCH    = 2 * GROUPS * LANES;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        aos_group #(
            .WORD_W(WORD_W), .SLOT_W(SLOT_W), .LANES(LANES),
            .NCH(NCH), .DIV_W(DIV_W), .GRP(g)
        ) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we[g]),
            .cfg_master(cfg_master[g]),
            .cfg_fmt   (fmt_e'(cfg_fmt[3*g +: 3])),
            .cfg_div   (cfg_div[DIV_W*g +: DIV_W]),
            .words     (ch_data),
            .bclk_in   (bclk_in[g]),
            .lrclk_in  (lrclk_in[g]),
            .bclk_o    (bclk_out[g]),
            .lrclk_o   (lrclk_out[g]),
            .oe        (clk_oe[g]),
            .sdata     (sdata_out[LANES*g +: LANES])
        );
    end

endmodule

// File: tb/audio_out_serializer_test.sv
module audio_out_serializer_test;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W = 24;
    localparam int SLOT_W = 32;
    localparam int LANES  = 4;
    localparam int DIV_W  = 8;
    localparam int NCH    = 16;
    localparam int WD_CYC = 180000;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [1:0]            cfg_we = '0, cfg_master = '0;
    logic [5:0]            cfg_fmt = '0;
    logic [2*DIV_W-1:0]    cfg_div = '0;
    logic [NCH*WORD_W-1:0] ch_data;
    logic [1:0]            bclk_in = '0, lrclk_in = '0;
    logic [1:0]            bclk_out, lrclk_out, clk_oe;
    logic [7:0]            sdata_out;
    logic [WORD_W-1:0]     words [NCH];

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    audio_out_serializer #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .LANES(LANES), .DIV_W(DIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_master(cfg_master),
        .cfg_fmt(cfg_fmt), .cfg_div(cfg_div), .ch_data(ch_data),
        .bclk_in(bclk_in), .lrclk_in(lrclk_in), .bclk_out(bclk_out),
        .lrclk_out(lrclk_out), .clk_oe(clk_oe), .sdata_out(sdata_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always_comb
        for (int i = 0; i < NCH; i++) ch_data[i*WORD_W +: WORD_W] = words[i];

    function automatic int frame_len(int f);
        if (f == 3) return 2 * LANES * SLOT_W;
        if (f == 4) return NCH * SLOT_W;
        return 2 * SLOT_W;
    endfunction

    function automatic bit exp_lr(int f, int pos);
        if (f == 3 || f == 4) return pos == 0;
        return pos >= SLOT_W;
    endfunction

    function automatic bit exp_bit(int f, int g, int p, int pos);
        int slot = pos / SLOT_W;
        int sb = pos % SLOT_W;
        int ch = 0;
        int k = -1;
        if (f <= 2) begin
            ch = g * 8 + 2 * p + slot;
            k = (f == 0) ? sb - 1 : (f == 1) ? sb : sb - (SLOT_W - WORD_W);
        end else if (f == 3 && p == 0) begin
            ch = g * 8 + slot; k = sb;
        end else if (f == 4 && g == 0 && p == 0) begin
            ch = slot; k = sb;
        end
        if (k < 0 || k >= WORD_W) return 1'b0;
        return words[ch][WORD_W-1-k];
    endfunction

    function automatic string fmt_tag(int f);
        case (f)
            0: return "R4 R7";
            1: return "R5 R7";
            2: return "R6 R7";
            3: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic new_words();
        for (int i = 0; i < NCH; i++) words[i] = WORD_W'($urandom);
    endtask

    task automatic configure(int g, bit m, int f, int d);
        @(negedge clk);
        bclk_in[g] = 1'b0; lrclk_in[g] = 1'b0;
        cfg_we[g] = 1'b1; cfg_master[g] = m;
        cfg_fmt[3*g +: 3] = 3'(f); cfg_div[DIV_W*g +: DIV_W] = DIV_W'(d);
        @(negedge clk);
        cfg_we[g] = 1'b0;
        check(clk_oe[g] == m, "R1", "clock direction after configuration", clk_oe[g], m);
    endtask

    // observe one full master frame of group g at the receiving (rising) edges
    task automatic capture_master(int g, int f, int d, string extra);
        int flen = frame_len(f);
        bit tdm = (f >= 3);
        int pos = -1, cyc = 0, hi = 0;
        int bad_lane [4];
        int act_lane [4];
        int exp_lane [4];
        int bad_lr = 0, bad_per = 0, bad_hi = 0, bad_chg = 0, per_act = 0, hi_act = 0;
        bit last_lr = 1'b0;
        bit prev_b = bclk_out[g];
        logic [3:0] prev_d = sdata_out[4*g +: 4];
        for (int p = 0; p < 4; p++) begin bad_lane[p] = 0; act_lane[p] = 0; exp_lane[p] = 0; end
        while (pos < flen) begin
            @(negedge clk);
            cyc++;
            if (sdata_out[4*g +: 4] != prev_d && !(prev_b && !bclk_out[g])) bad_chg++;
            prev_d = sdata_out[4*g +: 4];
            if (bclk_out[g]) hi++;
            if (prev_b && !bclk_out[g]) begin
                if (pos > 0 && hi != d / 2) begin bad_hi++; hi_act = hi; end
                hi = 0;
            end
            if (bclk_out[g] && !prev_b) begin
                if (pos < 0) begin
                    if (tdm ? lrclk_out[g] : (!lrclk_out[g] && last_lr)) pos = 0;
                    last_lr = lrclk_out[g];
                end
                if (pos >= 0) begin
                    if (pos > 0 && cyc != d) begin bad_per++; per_act = cyc; end
                    if (lrclk_out[g] != exp_lr(f, pos)) bad_lr++;
                    for (int p = 0; p < 4; p++)
                        if (sdata_out[4*g+p] != exp_bit(f, g, p, pos)) begin
                            if (bad_lane[p] == 0) begin
                                act_lane[p] = sdata_out[4*g+p];
                                exp_lane[p] = exp_bit(f, g, p, pos);
                            end
                            bad_lane[p]++;
                        end
                    pos++;
                end
                cyc = 0;
                hi = 1;
            end
            prev_b = bclk_out[g];
        end
        for (int p = 0; p < 4; p++)
            check(bad_lane[p] == 0, {fmt_tag(f), " ", extra},
                  $sformatf("master g%0d pin%0d first bad bit", g, p), act_lane[p], exp_lane[p]);
        check(bad_lr == 0, "R3", $sformatf("g%0d lrclk wrong positions", g), bad_lr, 0);
        check(bad_per == 0, "R2", $sformatf("g%0d bclk period", g), per_act, d);
        check(bad_hi == 0, "R2", $sformatf("g%0d bclk high phase", g), hi_act, d / 2);
        check(bad_chg == 0, "R13", $sformatf("g%0d data change off falling edge", g), bad_chg, 0);
    endtask

    // act as external clock master for group g: one lead frame, one checked frame
    task automatic capture_slave(int g, int f, int half);
        int flen = frame_len(f);
        int bad_hunt = 0, bad_ctl = 0;
        int bad_lane [4];
        for (int p = 0; p < 4; p++) bad_lane[p] = 0;
        for (int fr = 0; fr < 2; fr++)
            for (int pos = 0; pos < flen; pos++) begin
                @(negedge clk);
                bclk_in[g] = 1'b0;
                lrclk_in[g] = exp_lr(f, pos);
                repeat (half) @(negedge clk);
                if (fr == 0 && sdata_out[4*g +: 4] != 4'b0) bad_hunt++;
                if (clk_oe[g] || bclk_out[g] || lrclk_out[g]) bad_ctl++;
                if (fr == 1)
                    for (int p = 0; p < 4; p++)
                        if (sdata_out[4*g+p] != exp_bit(f, g, p, pos)) bad_lane[p]++;
                bclk_in[g] = 1'b1;
                repeat (half - 1) @(negedge clk);
            end
        if (f <= 2)
            check(bad_hunt == 0, "R11", $sformatf("g%0d nonzero pins before lock", g), bad_hunt, 0);
        check(bad_ctl == 0, "R10", $sformatf("g%0d slave drives clocks", g), bad_ctl, 0);
        for (int p = 0; p < 4; p++)
            check(bad_lane[p] == 0, {"R10 ", fmt_tag(f)},
                  $sformatf("slave g%0d pin%0d bad bits", g, p), bad_lane[p], 0);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYC);
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd424242));
        for (int i = 0; i < NCH; i++) words[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(clk_oe == 2'b00, "R1", "clk_oe after reset", clk_oe, 0);
        check(bclk_out == 2'b00 && lrclk_out == 2'b00, "R1", "clock outputs after reset",
              {bclk_out, lrclk_out}, 0);
        check(sdata_out == 8'h00, "R1", "data after reset", sdata_out, 0);
        new_words();
        repeat (20) @(negedge clk);
        check(sdata_out == 8'h00, "R11", "slave without clocks stays quiet", sdata_out, 0);

        // directed: two groups in different formats at once (R12)
        configure(0, 1, 0, 2);
        configure(1, 1, 2, 8);
        capture_master(0, 0, 2, "R12");
        capture_master(1, 2, 8, "R12");
        new_words();
        configure(0, 1, 1, 4);
        configure(1, 1, 3, 2);
        capture_master(0, 1, 4, "R12");
        capture_master(1, 3, 2, "R12");
        configure(0, 1, 3, 6);
        capture_master(0, 3, 6, "R8");
        capture_master(1, 3, 2, "R12");
        new_words();
        configure(0, 1, 4, 2);
        configure(1, 1, 4, 2);
        capture_master(0, 4, 2, "R9");
        capture_master(1, 4, 2, "R9");

        // directed slave cases
        configure(0, 0, 4, 2);
        capture_slave(0, 4, 4);
        configure(1, 0, 0, 2);
        capture_slave(1, 0, 4);
        new_words();
        configure(1, 0, 2, 2);
        capture_slave(1, 2, 4);

        // random segments
        for (int s = 0; s < 8; s++) begin
            int g = int'($urandom % 2);
            int f = int'($urandom % 5);
            bit m = bit'($urandom % 2);
            int d = 2 * (1 + int'($urandom % 4));
            new_words();
            configure(g, m, f, d);
            if (m) capture_master(g, f, d, "R12");
            else   capture_slave(g, f, 4);
        end

        done = 1;
        report();
        $finish;
    end

endmodule